// File: doc/BRIEF.md
# Three-Level PWM Command Decoder

This block turns a three-level PWM control line into one of three drive commands: HIGH (high-side switch on), LOW (low-side switch on) or OFF (both switches off). The analog level arrives as two comparator bits. `hi_cmp_i` is set when the line is above the upper threshold. `lo_cmp_i` is set when it is below the lower threshold. When neither bit is set, the line sits in the mid-level window. A controller parks the line in that window to shed a phase.

A mid-level input forces OFF only after it has stayed in the window for `HOLD_CYC` consecutive system-clock cycles. A shorter visit leaves the running command unchanged. Leaving the window toward either logic level takes effect on the next register stage, so the latency is only the synchronizer plus one cycle. Both comparator bits pass through a synchronizer of `SYNC_STAGES` flops. Both bits set at once is an illegal reading and is ignored. The `shutdown_o` flag feeds a downstream gate-drive sequencer.

The command state machine has three states. ST_OFF is the reset state and means both switches are off. ST_LOW means the low-side switch is on. ST_HIGH means the high-side switch is on. The transitions are:
- T_UP, from any state to ST_HIGH, on a synchronized high reading.
- T_DOWN, from any state to ST_LOW, on a synchronized low reading.
- T_PARK, from ST_LOW or ST_HIGH to ST_OFF, when the window timer expires.
- T_HOLD keeps the current state, on a window reading before expiry or on an illegal reading.

Top module: `tsp_decoder`

## Requirements
- R1: After reset, `cmd_o` is 2'b00 (OFF) and `shutdown_o` is 1. They stay so until a synchronized high or low reading is seen. An illegal reading after reset leaves them unchanged.
- R2: Command encoding is OFF=2'b00, LOW=2'b01, HIGH=2'b10, and 2'b11 never appears. With `hi_cmp_i`=1 and `lo_cmp_i`=0 held, `cmd_o` becomes 2'b10 on the (SYNC_STAGES+1)-th rising edge.
- R3: With `hi_cmp_i`=0 and `lo_cmp_i`=1 held, `cmd_o` becomes 2'b01 on the (SYNC_STAGES+1)-th rising edge.
- R4: With both inputs 0 held from a HIGH or LOW command, `cmd_o` becomes 2'b00 on the (SYNC_STAGES+HOLD_CYC)-th rising edge. It does not change one edge earlier.
- R5: A window visit shorter than HOLD_CYC cycles, followed by a return to the same level, leaves `cmd_o` unchanged in every cycle.
- R6: Leaving OFF toward HIGH or LOW takes exactly SYNC_STAGES+1 rising edges, the same as any other level change.
- R7: Both inputs at 1 (illegal) keep the previous command and restart the window count.
- R8: Window time does not accumulate across visits. Any cycle with a comparator bit set clears the count, so two visits of HOLD_CYC-1 cycles split by a one-cycle level pulse cause no shutdown.
- R9: `shutdown_o` is 1 exactly when `cmd_o` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hi_cmp_i | input | 1 | Comparator bit: line above the upper threshold |
| lo_cmp_i | input | 1 | Comparator bit: line below the lower threshold |
| cmd_o | output | 2 | Drive command: 00 OFF, 01 LOW, 10 HIGH |
| shutdown_o | output | 1 | Both switches off |

## Verification
The assertions work on the synchronized comparator bits. They take for granted that each raw bit is stable for at least one full clock period, so the synchronizer output is a clean copy delayed by SYNC_STAGES cycles. The stimulus meets this by changing the inputs only on falling edges and holding each value for whole cycles. Illegal both-high readings are applied on purpose, for whole cycles, to exercise the hold behaviour rather than as glitches.

// File: rtl/tsp_pkg.sv
package tsp_pkg;

    typedef enum logic [1:0] {
        CMD_OFF  = 2'b00,
        CMD_LOW  = 2'b01,
        CMD_HIGH = 2'b10
    } cmd_t;

    typedef enum logic [1:0] {
        LV_MID = 2'b00,
        LV_LO  = 2'b01,
        LV_HI  = 2'b10,
        LV_BAD = 2'b11
    } level_t;

    typedef enum logic [1:0] {
        ST_OFF  = 2'b00,
        ST_LOW  = 2'b01,
        ST_HIGH = 2'b10
    } state_t;

endpackage

// File: rtl/tsp_sync.sv
module tsp_sync #(
    parameter int STAGES = 2,
    parameter int W      = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] pipe_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe_q[i] <= '0;
        end else begin
            pipe_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
        end
    end

    assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/tsp_level_classify.sv
module tsp_level_classify
    import tsp_pkg::*;
(
    input  logic   hi_i,
    input  logic   lo_i,
    output level_t level_o
);
    always_comb begin
        unique case ({hi_i, lo_i})
            2'b10:   level_o = LV_HI;
            2'b01:   level_o = LV_LO;
            2'b11:   level_o = LV_BAD;
            default: level_o = LV_MID;
        endcase
    end
endmodule

// File: rtl/tsp_window_timer.sv
module tsp_window_timer
    import tsp_pkg::*;
#(
    parameter int HOLD_CYC = 8
) (
    input  logic   clk,
    input  logic   rst_n,
    input  level_t level_i,
    output logic   hold_done_o
);
    localparam int CW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

    logic [CW-1:0] cnt_q;
    logic          in_win;

    assign in_win = (level_i == LV_MID);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!in_win) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign hold_done_o = in_win && (cnt_q == LAST);
endmodule

// File: rtl/tsp_cmd_fsm.sv
module tsp_cmd_fsm
    import tsp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  level_t     level_i,
    input  logic       hold_done_i,
    output logic [1:0] cmd_o,
    output logic       shutdown_o
);
    state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (level_i)
            LV_HI:  state_d = ST_HIGH;
            LV_LO:  state_d = ST_LOW;
            LV_MID: if (hold_done_i) state_d = ST_OFF;
            LV_BAD: state_d = state_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_HIGH: begin cmd_o = CMD_HIGH; shutdown_o = 1'b0; end
            ST_LOW:  begin cmd_o = CMD_LOW;  shutdown_o = 1'b0; end
            default: begin cmd_o = CMD_OFF;  shutdown_o = 1'b1; end
        endcase
    end
endmodule

// File: rtl/tsp_decoder.sv
module tsp_decoder
    import tsp_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_CYC    = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hi_cmp_i,
    input  logic       lo_cmp_i,
    output logic [1:0] cmd_o,
    output logic       shutdown_o
);
    logic [1:0] sync_q;
    logic       hi_sync, lo_sync;
    level_t     level;
    logic       hold_done;

    tsp_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d_i({hi_cmp_i, lo_cmp_i}), .q_o(sync_q)
    );

    assign hi_sync = sync_q[1];
    assign lo_sync = sync_q[0];

    tsp_level_classify u_cls (
        .hi_i(hi_sync), .lo_i(lo_sync), .level_o(level)
    );

    tsp_window_timer #(.HOLD_CYC(HOLD_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .level_i(level), .hold_done_o(hold_done)
    );

    tsp_cmd_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .level_i(level), .hold_done_i(hold_done),
        .cmd_o(cmd_o), .shutdown_o(shutdown_o)
    );
endmodule

// File: rtl/tsp_decoder_chk.sv
module tsp_decoder_chk #(
    parameter int HOLD_CYC = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic       hi_s,
    input logic       lo_s,
    input logic [1:0] cmd_o,
    input logic       shutdown_o
);
    localparam int RW = $clog2(HOLD_CYC + 1) + 1;
    logic [RW-1:0] run_q;
    logic          mid;

    assign mid = !hi_s && !lo_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       run_q <= '0;
        else if (!mid)                    run_q <= '0;
        else if (run_q < RW'(HOLD_CYC))   run_q <= run_q + 1'b1;
    end

    AST_CMD_LEGAL:  assert property (@(posedge clk) disable iff (!rst_n)
        cmd_o != 2'b11);                                            // R2
    AST_HIGH_NEXT:  assert property (@(posedge clk) disable iff (!rst_n)
        (hi_s && !lo_s) |=> (cmd_o == 2'b10));                      // R6
    AST_LOW_NEXT:   assert property (@(posedge clk) disable iff (!rst_n)
        (!hi_s && lo_s) |=> (cmd_o == 2'b01));                      // R3
    AST_BAD_HOLD:   assert property (@(posedge clk) disable iff (!rst_n)
        (hi_s && lo_s) |=> $stable(cmd_o));                         // R7
    AST_PARK_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shutdown_o) |-> (run_q >= RW'(HOLD_CYC)));            // R5
    AST_SHUT_FLAG:  assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_o == (cmd_o == 2'b00));                            // R9
endmodule

bind tsp_decoder tsp_decoder_chk #(.HOLD_CYC(HOLD_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .hi_s(hi_sync), .lo_s(lo_sync),
    .cmd_o(cmd_o), .shutdown_o(shutdown_o)
);

// File: tb/tb_tsp_decoder.sv
module tb_tsp_decoder;
    localparam int SYNC = 2;
    localparam int HOLD = 8;
    localparam int NV   = 9;
    // {hi, lo, edges[5:0], expected[1:0], req_index[3:0]}
    localparam logic [13:0] VEC [NV] = '{
        {1'b1, 1'b0, 6'd3, 2'b10, 4'd6},   // R6 leave OFF to HIGH
        {1'b0, 1'b1, 6'd3, 2'b01, 4'd3},   // R3
        {1'b1, 1'b0, 6'd3, 2'b10, 4'd2},   // R2
        {1'b0, 1'b0, 6'd9, 2'b10, 4'd4},   // R4 one edge early: still HIGH
        {1'b0, 1'b0, 6'd1, 2'b00, 4'd4},   // R4 parked
        {1'b0, 1'b1, 6'd3, 2'b01, 4'd6},   // R6 leave OFF to LOW
        {1'b1, 1'b1, 6'd4, 2'b01, 4'd7},   // R7 illegal keeps LOW
        {1'b0, 1'b0, 6'd10, 2'b00, 4'd7},  // R7 count restarted after illegal
        {1'b1, 1'b0, 6'd3, 2'b10, 4'd2}    // R2
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hi = 1'b0, lo = 1'b0;
    logic [1:0] cmd;
    logic shut;
    int total = 0, fails = 0;

    always #10 clk = ~clk;

    tsp_decoder #(.SYNC_STAGES(SYNC), .HOLD_CYC(HOLD)) dut (
        .clk(clk), .rst_n(rst_n), .hi_cmp_i(hi), .lo_cmp_i(lo),
        .cmd_o(cmd), .shutdown_o(shut)
    );

    function automatic string rname(input int k);
        return $sformatf("R%0d", k);
    endfunction

    task automatic check(input logic [1:0] exp, input string req);
        total++;
        if (cmd !== exp || shut !== (exp == 2'b00)) begin
            fails++;
            $display("FAIL %s: cmd=%b shut=%b expected cmd=%b shut=%b",
                     req, cmd, shut, exp, (exp == 2'b00));
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; hi = 1'b0; lo = 1'b0;
        edges(2);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        do_reset();
        check(2'b00, "R1");                    // R1 reset state
        edges(HOLD + 4);
        check(2'b00, "R1");                    // R1 window after reset stays OFF

        for (int i = 0; i < NV; i++) begin
            hi = VEC[i][13]; lo = VEC[i][12];
            edges(int'(VEC[i][11:6]));
            check(VEC[i][5:4], $sformatf("%s row %0d", rname(int'(VEC[i][3:0])), i));
        end

        // R6 exact exit latency from OFF
        do_reset();
        hi = 1'b1;
        edges(SYNC);
        check(2'b00, "R6");
        edges(1);
        check(2'b10, "R6");

        // R5 short excursion, checked every cycle
        hi = 1'b0;
        for (int c = 0; c < HOLD - 1; c++) begin
            edges(1);
            check(2'b10, "R5");
        end
        hi = 1'b1;
        for (int c = 0; c < 4; c++) begin
            edges(1);
            check(2'b10, "R5");
        end

        // R8 split visits do not accumulate (from LOW)
        lo = 1'b1; hi = 1'b0;
        edges(SYNC + 1);
        check(2'b01, "R8");
        lo = 1'b0;
        edges(HOLD - 1);
        lo = 1'b1;
        edges(1);
        lo = 1'b0;
        for (int c = 0; c < HOLD - 1; c++) begin
            edges(1);
            check(2'b01, "R8");
        end
        lo = 1'b1;
        edges(SYNC + 2);
        check(2'b01, "R8");

        // R1/R7 illegal reading straight after reset
        do_reset();
        hi = 1'b1; lo = 1'b1;
        edges(SYNC + 3);
        check(2'b00, "R1");
        check(2'b00, "R9");

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule